// File: doc/BRIEF.md
# Register and Input-Output Operation Executor

This block carries out the two non-memory instruction groups of a 16-bit accumulator machine. When the control sequencer asserts the group-seven decode together with timing slot three, the block looks at the indirect flag. With the flag clear it applies accumulator and link-bit operations (clear, complement, rotate through the link bit, increment, conditional skips, halt). With the flag set it applies the input-output operations: character transfer between the accumulator and the 8-bit input and output holding registers, flag-based skips, and interrupt enable control. Each operation is picked by one bit of the low twelve instruction bits.

The block owns the accumulator, the link bit E, the program counter, the run flag, the interrupt enable, the two device flags and the two character registers. A neighbouring datapath writes AC, E and PC through a plain write port when no operation is executing. An external device loads the input register with a strobe and reports output completion with an acknowledge. In the execute cycle the block raises a sequence-counter clear so the sequencer restarts at slot zero.

Top module: `rr_exec_unit`

## Requirements
- R1: After reset AC=0, E=0, PC=0, run flag=1, IEN=0, FGI=0, FGO=1, INPR=0, OUTR=0.
- R2: An operation executes only when d7 and t3 are both high; `sc_clr` is high in exactly those cycles; with neither execution nor a write, AC, E and PC hold.
- R3: Register group (ind=0): sel[11] clears AC, sel[10] clears E, sel[9] inverts AC, sel[8] inverts E.
- R4: sel[7] rotates right through E (AC[15] gets E, E gets AC[0]); sel[6] rotates left through E (AC[0] gets E, E gets AC[15]).
- R5: sel[5] adds one to AC modulo 2^16 and leaves E unchanged.
- R6: Skips add one to PC: sel[4] if AC[15]=0, sel[3] if AC[15]=1, sel[2] if AC=0, sel[1] if E=0; tests use values before the instruction, and several true skips still add only one.
- R7: sel[0] in the register group clears the run flag.
- R8: I/O group (ind=1): sel[11] copies INPR into AC[7:0] keeping AC[15:8] and clears FGI; sel[10] copies AC[7:0] into OUTR and clears FGO.
- R9: I/O group: sel[9] skips if FGI=1, sel[8] skips if FGO=1, tested before the instruction.
- R10: I/O group: sel[7] sets IEN, sel[6] clears IEN; I/O sel[5:0] have no effect.
- R11: `in_strobe` loads INPR from `in_data` and sets FGI; `out_ack` sets FGO; each wins over a same-cycle clear by an instruction.
- R12: With several selection bits set, AC and E operations apply in descending bit order, each on the previous result (e.g. sel[11]+sel[5] gives AC=1; input then output sends the new low byte).
- R13: `wr_en` loads AC, E and PC from the write port, but is ignored in an execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d7 | input | 1 | Group-seven opcode decode |
| t3 | input | 1 | Timing slot three |
| ind | input | 1 | Indirect flag: 0 register group, 1 I/O group |
| sel | input | 12 | Low instruction bits selecting operations |
| wr_en | input | 1 | Datapath write enable |
| wr_ac | input | 16 | AC write value |
| wr_e | input | 1 | E write value |
| wr_pc | input | 12 | PC write value |
| in_strobe | input | 1 | Device has a new input character |
| in_data | input | 8 | Input character |
| out_ack | input | 1 | Device finished taking the output character |
| ac | output | 16 | Accumulator |
| e | output | 1 | Link bit |
| pc | output | 12 | Program counter |
| running | output | 1 | Run flag (0 means halted) |
| ien | output | 1 | Interrupt enable |
| fgi | output | 1 | Input-ready flag |
| fgo | output | 1 | Output-ready flag |
| inpr | output | 8 | Input character register |
| outr | output | 8 | Output character register |
| sc_clr | output | 1 | Sequence counter clear, combinational |

## Verification
Every state result (AC, E, PC, the flags and the two character registers) is due one clock edge after the cycle in which the execute, write, strobe or acknowledge inputs were held, while `sc_clr` is due in that same cycle. The bench drives inputs just after a falling edge, lets one rising edge pass, and compares at the next falling edge, when the registers have settled and the inputs still show the cycle that caused them. A behavioural reference model steps on the same rising edge and is compared on every falling edge, and directed checks with hand-worked values cover each requirement.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;
  // Selection bit positions; the positions are part of the instruction encoding.
  localparam int SB_CLR_AC = 11;
  localparam int SB_CLR_E  = 10;
  localparam int SB_INV_AC = 9;
  localparam int SB_INV_E  = 8;
  localparam int SB_ROT_R  = 7;
  localparam int SB_ROT_L  = 6;
  localparam int SB_INC    = 5;
  localparam int SB_SK_POS = 4;
  localparam int SB_SK_NEG = 3;
  localparam int SB_SK_ZRO = 2;
  localparam int SB_SK_EZ  = 1;
  localparam int SB_HALT   = 0;

  localparam int SB_IN     = 11;
  localparam int SB_OUT    = 10;
  localparam int SB_SK_FI  = 9;
  localparam int SB_SK_FO  = 8;
  localparam int SB_IEN_ON = 7;
  localparam int SB_IEN_OF = 6;
endpackage

// File: rtl/rr_regops.sv
module rr_regops
  import rr_exec_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEL_W = 12
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     ac_in,
  input  logic             e_in,
  output logic [W-1:0]     ac_out,
  output logic             e_out,
  output logic             skip,
  output logic             halt
);
  // rotate right through the link bit: {link, word} -> {word[0], {link, word[W-1:1]}}
  function automatic logic [W:0] rot_right(input logic [W-1:0] a, input logic l);
    return {a[0], l, a[W-1:1]};
  endfunction

  function automatic logic [W:0] rot_left(input logic [W-1:0] a, input logic l);
    return {a[W-1], a[W-2:0], l};
  endfunction

  function automatic logic [W-1:0] incr(input logic [W-1:0] a);
    return a + W'(1);
  endfunction

  always_comb begin
    logic [W-1:0] a;
    logic         l;
    logic [W:0]   r;
    a    = ac_in;
    l    = e_in;
    r    = '0;
    skip = 1'b0;
    halt = 1'b0;
    for (int b = SEL_W - 1; b >= 0; b--) begin
      if (sel[b]) begin
        case (b)
          SB_CLR_AC: a = '0;
          SB_CLR_E:  l = 1'b0;
          SB_INV_AC: a = ~a;
          SB_INV_E:  l = ~l;
          SB_ROT_R:  begin r = rot_right(a, l); l = r[W]; a = r[W-1:0]; end
          SB_ROT_L:  begin r = rot_left(a, l);  l = r[W]; a = r[W-1:0]; end
          SB_INC:    a = incr(a);
          SB_SK_POS: skip = skip | ~ac_in[W-1];
          SB_SK_NEG: skip = skip | ac_in[W-1];
          SB_SK_ZRO: skip = skip | (ac_in == '0);
          SB_SK_EZ:  skip = skip | ~e_in;
          SB_HALT:   halt = 1'b1;
          default:   ;
        endcase
      end
    end
    ac_out = a;
    e_out  = l;
  end
endmodule

// File: rtl/rr_ioops.sv
module rr_ioops
  import rr_exec_pkg::*;
#(
  parameter int W     = 16,
  parameter int IO_W  = 8,
  parameter int SEL_W = 12
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     ac_in,
  input  logic [IO_W-1:0]  inpr_in,
  input  logic             fgi_in,
  input  logic             fgo_in,
  input  logic             ien_in,
  output logic [W-1:0]     ac_out,
  output logic [IO_W-1:0]  outr_out,
  output logic             outr_ld,
  output logic             fgi_clr,
  output logic             fgo_clr,
  output logic             ien_out,
  output logic             skip
);
  always_comb begin
    logic [W-1:0] a;
    a        = ac_in;
    outr_out = '0;
    outr_ld  = 1'b0;
    fgi_clr  = 1'b0;
    fgo_clr  = 1'b0;
    ien_out  = ien_in;
    skip     = 1'b0;
    for (int b = SEL_W - 1; b >= 0; b--) begin
      if (sel[b]) begin
        case (b)
          SB_IN:     begin a[IO_W-1:0] = inpr_in; fgi_clr = 1'b1; end
          SB_OUT:    begin outr_out = a[IO_W-1:0]; outr_ld = 1'b1; fgo_clr = 1'b1; end
          SB_SK_FI:  skip = skip | fgi_in;
          SB_SK_FO:  skip = skip | fgo_in;
          SB_IEN_ON: ien_out = 1'b1;
          SB_IEN_OF: ien_out = 1'b0;
          default:   ;
        endcase
      end
    end
    ac_out = a;
  end
endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit #(
  parameter int W      = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8,
  parameter int SEL_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d7,
  input  logic              t3,
  input  logic              ind,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_ac,
  input  logic              wr_e,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic              in_strobe,
  input  logic [IO_W-1:0]   in_data,
  input  logic              out_ack,
  output logic [W-1:0]      ac,
  output logic              e,
  output logic [ADDR_W-1:0] pc,
  output logic              running,
  output logic              ien,
  output logic              fgi,
  output logic              fgo,
  output logic [IO_W-1:0]   inpr,
  output logic [IO_W-1:0]   outr,
  output logic              sc_clr
);
  // named internal events
  logic exec_evt, reg_evt, io_evt, skip_evt, halt_evt;

  logic [W-1:0]    rg_ac, io_ac;
  logic            rg_e, rg_skip, rg_halt;
  logic [IO_W-1:0] io_outr;
  logic            io_outr_ld, io_fgi_clr, io_fgo_clr, io_ien, io_skip;

  assign exec_evt = d7 & t3;
  assign reg_evt  = exec_evt & ~ind;
  assign io_evt   = exec_evt & ind;
  assign skip_evt = (reg_evt & rg_skip) | (io_evt & io_skip);
  assign halt_evt = reg_evt & rg_halt;
  assign sc_clr   = exec_evt;

  rr_regops #(.W(W), .SEL_W(SEL_W)) u_reg (
    .sel(sel), .ac_in(ac), .e_in(e),
    .ac_out(rg_ac), .e_out(rg_e), .skip(rg_skip), .halt(rg_halt)
  );

  rr_ioops #(.W(W), .IO_W(IO_W), .SEL_W(SEL_W)) u_io (
    .sel(sel), .ac_in(ac), .inpr_in(inpr), .fgi_in(fgi), .fgo_in(fgo), .ien_in(ien),
    .ac_out(io_ac), .outr_out(io_outr), .outr_ld(io_outr_ld),
    .fgi_clr(io_fgi_clr), .fgo_clr(io_fgo_clr), .ien_out(io_ien), .skip(io_skip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac      <= '0;
      e       <= 1'b0;
      pc      <= '0;
      running <= 1'b1;
      ien     <= 1'b0;
      fgi     <= 1'b0;
      fgo     <= 1'b1;
      inpr    <= '0;
      outr    <= '0;
    end else begin
      if (reg_evt) begin
        ac <= rg_ac;
        e  <= rg_e;
      end else if (io_evt) begin
        ac <= io_ac;
      end else if (wr_en) begin
        ac <= wr_ac;
        e  <= wr_e;
      end

      if (exec_evt) begin
        if (skip_evt) pc <= pc + ADDR_W'(1);
      end else if (wr_en) begin
        pc <= wr_pc;
      end

      if (halt_evt) running <= 1'b0;
      if (io_evt)   ien <= io_ien;

      if (in_strobe) begin
        inpr <= in_data;
        fgi  <= 1'b1;
      end else if (io_evt && io_fgi_clr) begin
        fgi <= 1'b0;
      end

      if (out_ack)                      fgo <= 1'b1;
      else if (io_evt && io_fgo_clr)    fgo <= 1'b0;

      if (io_evt && io_outr_ld) outr <= io_outr;
    end
  end
endmodule

// File: rtl/rr_exec_chk.sv
module rr_exec_chk #(
  parameter int W      = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8,
  parameter int SEL_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              d7,
  input logic              t3,
  input logic              ind,
  input logic [SEL_W-1:0]  sel,
  input logic              wr_en,
  input logic              in_strobe,
  input logic [IO_W-1:0]   in_data,
  input logic [W-1:0]      ac,
  input logic              e,
  input logic [ADDR_W-1:0] pc,
  input logic              running,
  input logic              ien,
  input logic              fgi,
  input logic [IO_W-1:0]   inpr
);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(d7 && t3) && !wr_en) |=> ($stable(ac) && $stable(e) && $stable(pc)));

  // R4
  rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d7 && t3 && !ind && sel == SEL_W'(12'h080))
      |=> (ac == {$past(e), $past(ac[W-1:1])} && e == $past(ac[0])));

  // R6
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d7 && t3 && !ind && sel[2] && ac == '0) |=> ((pc - $past(pc)) == ADDR_W'(1)));

  // R7
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d7 && t3 && !ind && sel[0]) |=> !running);

  // R8
  input_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d7 && t3 && ind && sel == SEL_W'(12'h800) && !in_strobe)
      |=> (ac[IO_W-1:0] == $past(inpr) && !fgi));

  // R10
  ien_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d7 && t3 && ind && sel[6]) |=> !ien);

  // R11
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> (fgi && inpr == $past(in_data)));
endmodule

bind rr_exec_unit rr_exec_chk #(.W(W), .ADDR_W(ADDR_W), .IO_W(IO_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .d7(d7), .t3(t3), .ind(ind), .sel(sel), .wr_en(wr_en),
  .in_strobe(in_strobe), .in_data(in_data), .ac(ac), .e(e), .pc(pc),
  .running(running), .ien(ien), .fgi(fgi), .inpr(inpr)
);

// File: tb/rr_exec_unit_bench.sv
module rr_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d7 = 0, t3 = 0, ind = 0, wr_en = 0, wr_e = 0, in_strobe = 0, out_ack = 0;
  logic [11:0] sel = '0, wr_pc = '0;
  logic [15:0] wr_ac = '0;
  logic [7:0]  in_data = '0;
  logic [15:0] ac;
  logic        e, running, ien, fgi, fgo, sc_clr;
  logic [11:0] pc;
  logic [7:0]  inpr, outr;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  // reference model state
  logic [15:0] m_ac; logic m_e, m_run, m_ien, m_fgi, m_fgo;
  logic [11:0] m_pc; logic [7:0] m_inpr, m_outr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_exec_unit u_rr_exec_unit (
    .clk(clk), .rst_n(rst_n), .d7(d7), .t3(t3), .ind(ind), .sel(sel),
    .wr_en(wr_en), .wr_ac(wr_ac), .wr_e(wr_e), .wr_pc(wr_pc),
    .in_strobe(in_strobe), .in_data(in_data), .out_ack(out_ack),
    .ac(ac), .e(e), .pc(pc), .running(running), .ien(ien), .fgi(fgi), .fgo(fgo),
    .inpr(inpr), .outr(outr), .sc_clr(sc_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: walk the selected bits from the top down
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ac = 0; m_e = 0; m_pc = 0; m_run = 1; m_ien = 0;
      m_fgi = 0; m_fgo = 1; m_inpr = 0; m_outr = 0;
    end else begin
      logic [15:0] a0, a; logic e0, x, sk, fi0, fo0, clr_i, clr_o; logic [7:0] ip0;
      a0 = m_ac; e0 = m_e; fi0 = m_fgi; fo0 = m_fgo; ip0 = m_inpr;
      a = a0; x = e0; sk = 0; clr_i = 0; clr_o = 0;
      if (d7 && t3) begin
        for (int b = 11; b >= 0; b--) begin
          if (!sel[b]) continue;
          if (!ind) begin
            if (b == 11) a = 0;
            else if (b == 10) x = 0;
            else if (b == 9) a = a ^ 16'hFFFF;
            else if (b == 8) x = !x;
            else if (b == 7) begin logic t; t = a[0]; a = (a >> 1) | (16'(x) << 15); x = t; end
            else if (b == 6) begin logic t; t = a[15]; a = (a << 1) | 16'(x); x = t; end
            else if (b == 5) a = 16'((int'(a) + 1) % 65536);
            else if (b == 4) sk = sk | (a0 < 16'h8000);
            else if (b == 3) sk = sk | (a0 >= 16'h8000);
            else if (b == 2) sk = sk | (a0 == 0);
            else if (b == 1) sk = sk | (e0 == 0);
            else m_run = 0;
          end else begin
            if (b == 11) begin a = (a & 16'hFF00) | 16'(ip0); clr_i = 1; end
            else if (b == 10) begin m_outr = a[7:0]; clr_o = 1; end
            else if (b == 9) sk = sk | fi0;
            else if (b == 8) sk = sk | fo0;
            else if (b == 7) m_ien = 1;
            else if (b == 6) m_ien = 0;
          end
        end
        m_ac = a; m_e = x;
        if (sk) m_pc = m_pc + 1;
        if (clr_i) m_fgi = 0;
        if (clr_o) m_fgo = 0;
      end else if (wr_en) begin
        m_ac = wr_ac; m_e = wr_e; m_pc = wr_pc;
      end
      if (in_strobe) begin m_inpr = in_data; m_fgi = 1; end
      if (out_ack) m_fgo = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 model ac", 32'(ac), 32'(m_ac));
      chk("R4 model e", 32'(e), 32'(m_e));
      chk("R6 model pc", 32'(pc), 32'(m_pc));
      chk("R7 model run", 32'(running), 32'(m_run));
      chk("R10 model ien", 32'(ien), 32'(m_ien));
      chk("R11 model fgi", 32'(fgi), 32'(m_fgi));
      chk("R11 model fgo", 32'(fgo), 32'(m_fgo));
      chk("R11 model inpr", 32'(inpr), 32'(m_inpr));
      chk("R8 model outr", 32'(outr), 32'(m_outr));
      chk("R2 model sc_clr", 32'(sc_clr), 32'(d7 && t3));
    end
  end

  task automatic idle_inputs();
    d7 = 0; t3 = 0; ind = 0; sel = 0; wr_en = 0; in_strobe = 0; out_ack = 0;
  endtask

  task automatic finish_cycle();
    @(negedge clk); #1; idle_inputs();
  endtask

  task automatic op(input logic i, input logic [11:0] s);
    d7 = 1; t3 = 1; ind = i; sel = s; finish_cycle();
  endtask

  task automatic wr(input logic [15:0] a, input logic x, input logic [11:0] p);
    wr_en = 1; wr_ac = a; wr_e = x; wr_pc = p; finish_cycle();
  endtask

  task automatic strobe(input logic [7:0] d);
    in_strobe = 1; in_data = d; finish_cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1; rst_n = 1; cmp_on = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 ac", 32'(ac), 0); chk("R1 e", 32'(e), 0); chk("R1 pc", 32'(pc), 0);
    chk("R1 run", 32'(running), 1); chk("R1 ien", 32'(ien), 0);
    chk("R1 fgi", 32'(fgi), 0); chk("R1 fgo", 32'(fgo), 1);
    chk("R1 outr", 32'(outr), 0); chk("R1 inpr", 32'(inpr), 0);

    // R13 write port
    wr(16'h8001, 1, 12'h010);
    chk("R13 write ac", 32'(ac), 32'h8001); chk("R13 write pc", 32'(pc), 32'h010);

    // R4 rotates, E set and clear
    op(0, 12'h080); chk("R4 rotr E=1 ac", 32'(ac), 32'hC000); chk("R4 rotr E=1 e", 32'(e), 1);
    wr(16'h8001, 0, 12'h010);
    op(0, 12'h080); chk("R4 rotr E=0 ac", 32'(ac), 32'h4000); chk("R4 rotr E=0 e", 32'(e), 1);
    wr(16'h8001, 1, 12'h010);
    op(0, 12'h040); chk("R4 rotl E=1 ac", 32'(ac), 32'h0003); chk("R4 rotl E=1 e", 32'(e), 1);
    wr(16'h4000, 0, 12'h010);
    op(0, 12'h040); chk("R4 rotl E=0 ac", 32'(ac), 32'h8000); chk("R4 rotl E=0 e", 32'(e), 0);

    // R5 increment wraps, E unchanged
    wr(16'hFFFF, 1, 12'h010);
    op(0, 12'h020); chk("R5 inc wrap", 32'(ac), 0); chk("R5 inc keeps E", 32'(e), 1);

    // R3 clear / complement
    wr(16'h1234, 0, 12'h010);
    op(0, 12'h900); chk("R3 clear ac", 32'(ac), 0); chk("R3 invert e", 32'(e), 1);
    op(0, 12'h400); chk("R3 clear e", 32'(e), 0);
    wr(16'h00FF, 0, 12'h010);
    op(0, 12'h200); chk("R3 invert ac", 32'(ac), 32'hFF00);

    // R6 skips
    wr(16'h0000, 0, 12'h010);
    op(0, 12'h004); chk("R6 zero skip", 32'(pc), 32'h011);
    op(0, 12'h016); chk("R6 single increment", 32'(pc), 32'h012);
    op(0, 12'h008); chk("R6 neg no skip", 32'(pc), 32'h012);
    wr(16'h8000, 1, 12'h020);
    op(0, 12'h008); chk("R6 neg skip", 32'(pc), 32'h021);
    op(0, 12'h012); chk("R6 pos and ez no skip", 32'(pc), 32'h021);

    // R12 ordering and pre-instruction tests
    wr(16'hFFFF, 0, 12'h030);
    op(0, 12'h024); chk("R12 inc then zero test pre ac", 32'(ac), 0);
    chk("R12 no skip on pre value", 32'(pc), 32'h030);
    wr(16'h5555, 0, 12'h030);
    op(0, 12'h820); chk("R12 clear then inc", 32'(ac), 1);

    // R2 no execution without both strobes
    wr(16'h1234, 1, 12'h040);
    d7 = 1; t3 = 0; sel = 12'h800; #1; chk("R2 sc_clr low", 32'(sc_clr), 0); finish_cycle();
    chk("R2 d7 only holds ac", 32'(ac), 32'h1234);
    d7 = 0; t3 = 1; sel = 12'hC00; finish_cycle();
    chk("R2 t3 only holds e", 32'(e), 1);
    d7 = 1; t3 = 1; sel = 12'h000; #1; chk("R2 sc_clr high", 32'(sc_clr), 1); finish_cycle();

    // R13 write ignored during execute
    d7 = 1; t3 = 1; sel = 12'h020; wr_en = 1; wr_ac = 16'h7777; wr_pc = 12'h0AA; finish_cycle();
    chk("R13 exec wins ac", 32'(ac), 32'h1235); chk("R13 exec wins pc", 32'(pc), 32'h040);

    // R7 halt
    op(0, 12'h001); chk("R7 halted", 32'(running), 0);

    // R8, R9, R11 input/output
    strobe(8'hA5); chk("R11 strobe fgi", 32'(fgi), 1); chk("R11 strobe inpr", 32'(inpr), 32'hA5);
    wr(16'h1200, 0, 12'h050);
    op(1, 12'h200); chk("R9 ski skip", 32'(pc), 32'h051);
    op(1, 12'h800); chk("R8 input ac", 32'(ac), 32'h12A5); chk("R8 input clears fgi", 32'(fgi), 0);
    op(1, 12'h200); chk("R9 ski no skip", 32'(pc), 32'h051);
    op(1, 12'h100); chk("R9 sko skip", 32'(pc), 32'h052);
    op(1, 12'h400); chk("R8 output outr", 32'(outr), 32'hA5); chk("R8 output clears fgo", 32'(fgo), 0);
    op(1, 12'h100); chk("R9 sko no skip", 32'(pc), 32'h052);
    out_ack = 1; finish_cycle(); chk("R11 ack sets fgo", 32'(fgo), 1);

    // R12 input then output in one instruction
    strobe(8'h3C);
    op(1, 12'hC00); chk("R12 output sees new byte", 32'(outr), 32'h3C);

    // R11 strobe beats same-cycle clear
    strobe(8'h11);
    d7 = 1; t3 = 1; ind = 1; sel = 12'h800; in_strobe = 1; in_data = 8'h22; finish_cycle();
    chk("R11 strobe wins fgi", 32'(fgi), 1); chk("R11 new inpr", 32'(inpr), 32'h22);
    chk("R11 ac took old inpr", 32'(ac[7:0]), 32'h11);
    d7 = 1; t3 = 1; ind = 1; sel = 12'h400; out_ack = 1; finish_cycle();
    chk("R11 ack wins fgo", 32'(fgo), 1);

    // R10 interrupt enable
    op(1, 12'h080); chk("R10 ien on", 32'(ien), 1);
    wr(16'h4321, 1, 12'h060);
    op(1, 12'h03F); chk("R10 low bits ac", 32'(ac), 32'h4321);
    chk("R10 low bits pc", 32'(pc), 32'h060); chk("R10 low bits ien", 32'(ien), 1);
    op(1, 12'h0C0); chk("R10 both bits clear", 32'(ien), 0);

    repeat (3) finish_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule